// File: doc/BRIEF.md
# Auxiliary GPIO Port with Interrupt Lines and Reset Straps

This block provides an eight-line general-purpose I/O port controlled through a small register bus. Each line has an output latch and a direction bit. The synchronized level of every pad can be read back. Two lines, 6 and 7, feed interrupt channels. Each channel has its own enable and can detect either a falling edge, which is held until cleared, or an active-low level.

While reset is held, the levels on lines 3, 4 and 5 are sampled every clock. The values present at reset release are frozen into a strap register. Lines 4 and 5 carry a two-bit system version number and line 3 flags that an EEPROM is present.

A configuration bit hands lines 3 to 6 over to a serial EEPROM link. The serial engine sits outside the block. Its chip select, data out and clock are routed to the pads, and the pad level on line 4 is returned as serial data in.

Top module: `aux_gpio_port`

## Requirements
- R1: After reset, registers OUT (addr 0), DIR (addr 1), ENABLE (addr 4) and CONFIG (addr 5) read 0, every pad_oe bit is 0 and irq is 0.
- R2: Outside serial mode, pad_oe[i] equals DIR bit i (1 = drive) and pad_out[i] equals OUT bit i.
- R3: Register PIN (addr 2) returns the pad_in levels after a two-flop synchronizer, so they are visible two clock edges after a change. Writes to PIN are ignored.
- R4: In edge mode (CONFIG bit 0 for line 6, bit 1 for line 7, 1 = edge), a falling edge sets STATUS (addr 3) bit 0 or bit 1. The bit stays set until a 1 is written to that bit position. Writing 0 leaves it set.
- R5: In level mode (CONFIG bit = 0), the STATUS bit reads 1 exactly while the synchronized pad is low. Writes do not change it.
- R6: irq is 1 exactly when some STATUS bit and the matching ENABLE bit are both 1. A disabled channel still sets its STATUS bit.
- R7: STRAP (addr 6) holds {line 3, line 5, line 4} in bits [2:0] as sampled at the last clock edge before reset release. Pad changes after reset leave it unchanged.
- R8: With CONFIG bit 2 set, pad 3 carries spi_cs, pad 5 carries spi_mosi and pad 6 carries spi_sck, all driven regardless of DIR. Pad 4 is not driven, and spi_miso follows pad_in[4].
- R9: In serial mode the line-6 interrupt source is blocked: a falling edge on pad 6 does not set STATUS bit 0, and in level mode that bit reads 0.
- R10: Reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad drive enables, 1 = drive |
| spi_cs | input | 1 | Chip select from the serial engine |
| spi_mosi | input | 1 | Serial data out from the serial engine |
| spi_sck | input | 1 | Serial clock from the serial engine |
| spi_miso | output | 1 | Serial data in returned to the serial engine |
| irq | output | 1 | Interrupt request |

## Verification
The direction and readback logic is driven with a table of patterns: all inputs, all outputs, alternating bits and a walking single output. These patterns separate the drive-enable path from the output latch and from the synchronized readback.

The interrupt channels are tried with a pulse on a disabled line, a held low level, and a clear written while the pad is still high after an edge. Together these separate sticky edge capture from level following and from masking.

Two resets with opposite strap patterns, followed by pad changes, show that the strap register keeps the release-time levels. A serial-mode pass shows that the muxed pins override DIR and that a clock toggle on line 6 raises no interrupt.

// File: rtl/aux_gpio_pkg.sv
package aux_gpio_pkg;

   localparam int unsigned REG_AW      = 3;
   localparam int unsigned CFG_W       = 3;
   localparam int unsigned CFG_SPI_BIT = 2;
   localparam int unsigned STRAP_W     = 3;

   typedef enum logic [REG_AW-1:0] {
      A_OUT   = 3'd0,
      A_DIR   = 3'd1,
      A_PIN   = 3'd2,
      A_STAT  = 3'd3,
      A_EN    = 3'd4,
      A_CFG   = 3'd5,
      A_STRAP = 3'd6
   } reg_addr_e;

endpackage

// File: rtl/aux_gpio_sync.sv
module aux_gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aux_gpio_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/aux_gpio_irq_ch.sv
module aux_gpio_irq_ch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic edge_mode,
   input  logic src_ok,
   input  logic clr,
   output logic stat
);

   logic prev_q;
   logic sticky_q;
   logic fall;

   assign fall = prev_q & ~pin_s & src_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         prev_q   <= pin_s;
         sticky_q <= fall | (sticky_q & ~clr);
      end
   end

   assign stat = edge_mode ? sticky_q : (~pin_s & src_ok);

endmodule

// File: rtl/aux_gpio_pinmux.sv
module aux_gpio_pinmux #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned CS_LINE   = 3,
   parameter int unsigned MISO_LINE = 4,
   parameter int unsigned MOSI_LINE = 5,
   parameter int unsigned SCK_LINE  = 6
) (
   input  logic [NUM_LINES-1:0] out_reg,
   input  logic [NUM_LINES-1:0] dir_reg,
   input  logic                 spi_mode,
   input  logic                 spi_cs,
   input  logic                 spi_mosi,
   input  logic                 spi_sck,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic                 spi_miso
);

   always_comb begin
      pad_out = out_reg;
      pad_oe  = dir_reg;
      if (spi_mode) begin
         pad_out[CS_LINE]   = spi_cs;
         pad_oe[CS_LINE]    = 1'b1;
         pad_out[MOSI_LINE] = spi_mosi;
         pad_oe[MOSI_LINE]  = 1'b1;
         pad_out[SCK_LINE]  = spi_sck;
         pad_oe[SCK_LINE]   = 1'b1;
         pad_oe[MISO_LINE]  = 1'b0;
      end
   end

   assign spi_miso = pad_in[MISO_LINE];

endmodule

// File: rtl/aux_gpio_port.sv
module aux_gpio_port
   import aux_gpio_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INT_LINE_A  = 6,
   parameter int unsigned INT_LINE_B  = 7,
   parameter int unsigned CS_LINE     = 3,
   parameter int unsigned MISO_LINE   = 4,
   parameter int unsigned MOSI_LINE   = 5,
   parameter int unsigned SCK_LINE    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   input  logic                 spi_cs,
   input  logic                 spi_mosi,
   input  logic                 spi_sck,
   output logic                 spi_miso,
   output logic                 irq
);

   localparam int unsigned NUM_IRQ = 2;
   localparam int unsigned IRQ_LINE [NUM_IRQ] = '{INT_LINE_A, INT_LINE_B};

   if (NUM_LINES < CFG_W || NUM_LINES < STRAP_W) begin : g_bad_width
      $error("aux_gpio_port: NUM_LINES too small for config fields");
   end
   if (INT_LINE_A >= NUM_LINES || INT_LINE_B >= NUM_LINES ||
       INT_LINE_A == INT_LINE_B) begin : g_bad_int
      $error("aux_gpio_port: interrupt lines invalid");
   end
   if (CS_LINE >= NUM_LINES || MISO_LINE >= NUM_LINES ||
       MOSI_LINE >= NUM_LINES || SCK_LINE >= NUM_LINES) begin : g_bad_spi
      $error("aux_gpio_port: serial lines out of range");
   end

   logic [NUM_LINES-1:0] out_q, dir_q, pin_s;
   logic [NUM_IRQ-1:0]   en_q, irq_stat;
   logic [CFG_W-1:0]     cfg_q;
   logic [STRAP_W-1:0]   strap_q;
   logic                 spi_mode;
   reg_addr_e            addr;

   assign addr     = reg_addr_e'(reg_addr);
   assign spi_mode = cfg_q[CFG_SPI_BIT];

   // Straps: sampled every clock while reset is low, frozen at release.
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= {pad_in[CS_LINE], pad_in[MOSI_LINE], pad_in[MISO_LINE]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         en_q  <= '0;
         cfg_q <= '0;
      end else if (reg_wr) begin
         case (addr)
            A_OUT: out_q <= reg_wdata;
            A_DIR: dir_q <= reg_wdata;
            A_EN:  en_q  <= reg_wdata[NUM_IRQ-1:0];
            A_CFG: cfg_q <= reg_wdata[CFG_W-1:0];
            default: ;
         endcase
      end
   end

   aux_gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
   );

   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      logic src_ok;
      logic clr;
      assign src_ok = !(spi_mode && (IRQ_LINE[k] == SCK_LINE));
      assign clr    = reg_wr && (addr == A_STAT) && reg_wdata[k];
      aux_gpio_irq_ch u_ch (
         .clk(clk), .rst_n(rst_n), .pin_s(pin_s[IRQ_LINE[k]]),
         .edge_mode(cfg_q[k]), .src_ok(src_ok), .clr(clr), .stat(irq_stat[k])
      );
   end

   aux_gpio_pinmux #(
      .NUM_LINES(NUM_LINES), .CS_LINE(CS_LINE), .MISO_LINE(MISO_LINE),
      .MOSI_LINE(MOSI_LINE), .SCK_LINE(SCK_LINE)
   ) u_mux (
      .out_reg(out_q), .dir_reg(dir_q), .spi_mode(spi_mode),
      .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_sck(spi_sck),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .spi_miso(spi_miso)
   );

   always_comb begin
      reg_rdata = '0;
      case (addr)
         A_OUT:   reg_rdata = out_q;
         A_DIR:   reg_rdata = dir_q;
         A_PIN:   reg_rdata = pin_s;
         A_STAT:  reg_rdata[NUM_IRQ-1:0] = irq_stat;
         A_EN:    reg_rdata[NUM_IRQ-1:0] = en_q;
         A_CFG:   reg_rdata[CFG_W-1:0]   = cfg_q;
         A_STRAP: reg_rdata[STRAP_W-1:0] = strap_q;
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |(irq_stat & en_q);

endmodule

// File: rtl/aux_gpio_chk.sv
module aux_gpio_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   reg_addr,
   input logic         reg_wr,
   input logic [N-1:0] reg_wdata,
   input logic [N-1:0] pad_oe,
   input logic         irq,
   input logic [1:0]   stat,
   input logic [1:0]   edge_mode,
   input logic         spi_mode,
   input logic [2:0]   strap
);

   // R2
   dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd1 && !spi_mode) |=> (pad_oe[2:0] == $past(reg_wdata[2:0])));

   // R4
   edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[1] && stat[1] && !(reg_wr && reg_addr == 3'd3 && reg_wdata[1])
       && !(reg_wr && reg_addr == 3'd5)) |=> stat[1]);

   // R6
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 2'b00) |-> !irq);

   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (stat != 2'b00));

   // R7
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(strap));

   // R8
   spi_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_mode |-> (pad_oe[3] && pad_oe[5] && pad_oe[6] && !pad_oe[4]));

   // R9
   spi_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_mode && $past(spi_mode) && $stable(edge_mode)) |-> !$rose(stat[0]));

endmodule

bind aux_gpio_port aux_gpio_chk #(.N(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .pad_oe(pad_oe), .irq(irq), .stat(irq_stat),
   .edge_mode(cfg_q[1:0]), .spi_mode(cfg_q[2]), .strap(strap_q)
);

// File: tb/tb_aux_gpio_port.sv
module tb_aux_gpio_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pad_in = 8'hD8;
   logic [7:0] pad_out, pad_oe;
   logic       spi_cs = 1'b0, spi_mosi = 1'b0, spi_sck = 1'b0;
   logic       spi_miso, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   aux_gpio_port dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .spi_cs(spi_cs), .spi_mosi(spi_mosi),
      .spi_sck(spi_sck), .spi_miso(spi_miso), .irq(irq)
   );

   // {dir, out, pad}
   localparam logic [23:0] VEC [6] = '{
      {8'h00, 8'hFF, 8'hA5},
      {8'hFF, 8'h3C, 8'h5A},
      {8'hAA, 8'h55, 8'hF0},
      {8'h55, 8'hAA, 8'h0F},
      {8'h01, 8'h01, 8'hC3},
      {8'h80, 8'h80, 8'hFF}
   };

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      pad_in = 8'hC0;
      settle();

      // R1 reset state
      chk(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 8'h00);
      chk(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
      for (int a = 0; a < 6; a++) begin
         if (a == 2 || a == 3) continue;
         rd(3'(a), v);
         chk(v == 8'h00, "R1 register", v, 8'h00);
      end

      // R7 straps from first reset: line3=1 line5=0 line4=1
      rd(3'd6, v);
      chk(v == 8'h05, "R7 strap", v, 8'h05);

      // R10 unmapped
      rd(3'd7, v);
      chk(v == 8'h00, "R10 unmapped", v, 8'h00);

      // R2 R3 table
      for (int i = 0; i < 6; i++) begin
         logic [7:0] d, o, p;
         {d, o, p} = VEC[i];
         wr(3'd1, d);
         wr(3'd0, o);
         pad_in = p;
         settle();
         chk(pad_oe == d, "R2 pad_oe", pad_oe, d);
         chk((pad_out & d) == (o & d), "R2 pad_out", pad_out & d, o & d);
         rd(3'd2, v);
         chk(v == p, "R3 pin readback", v, p);
      end
      wr(3'd2, 8'h00);
      rd(3'd2, v);
      chk(v == 8'hFF, "R3 pin write ignored", v, 8'hFF);

      // R4 R6 edge mode on line 6, disabled first
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h01);
      pad_in[6] = 1'b0; settle();
      pad_in[6] = 1'b1; settle();
      rd(3'd3, v);
      chk(v[0] == 1'b1, "R4 edge captured", v, 8'h01);
      chk(irq == 1'b0, "R6 masked irq low", {7'd0, irq}, 8'h00);
      wr(3'd4, 8'h01);
      @(negedge clk);
      chk(irq == 1'b1, "R6 irq high", {7'd0, irq}, 8'h01);
      wr(3'd3, 8'h00);
      rd(3'd3, v);
      chk(v[0] == 1'b1, "R4 write 0 keeps", v, 8'h01);
      wr(3'd3, 8'h01);
      rd(3'd3, v);
      chk(v[0] == 1'b0, "R4 write 1 clears", v, 8'h00);
      chk(irq == 1'b0, "R6 irq after clear", {7'd0, irq}, 8'h00);

      // R5 level mode on line 7
      wr(3'd4, 8'h02);
      pad_in[7] = 1'b0; settle();
      rd(3'd3, v);
      chk(v[1] == 1'b1, "R5 level low", v, 8'h02);
      chk(irq == 1'b1, "R6 level irq", {7'd0, irq}, 8'h01);
      wr(3'd3, 8'h02);
      rd(3'd3, v);
      chk(v[1] == 1'b1, "R5 write no effect", v, 8'h02);
      pad_in[7] = 1'b1; settle();
      rd(3'd3, v);
      chk(v[1] == 1'b0, "R5 level follows high", v, 8'h00);

      // R8 serial mode
      wr(3'd4, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h05);
      spi_cs = 1'b1; spi_mosi = 1'b1; spi_sck = 1'b0;
      #1;
      chk((pad_oe & 8'h78) == 8'h68, "R8 serial enables", pad_oe & 8'h78, 8'h68);
      chk((pad_out & 8'h68) == 8'h28, "R8 serial outputs", pad_out & 8'h68, 8'h28);
      pad_in[4] = 1'b0; #1;
      chk(spi_miso == 1'b0, "R8 miso low", {7'd0, spi_miso}, 8'h00);
      pad_in[4] = 1'b1; #1;
      chk(spi_miso == 1'b1, "R8 miso high", {7'd0, spi_miso}, 8'h01);

      // R9 clock toggles on line 6 raise nothing
      pad_in[6] = 1'b0; settle();
      pad_in[6] = 1'b1; settle();
      rd(3'd3, v);
      chk(v[0] == 1'b0, "R9 edge blocked", v, 8'h00);
      wr(3'd5, 8'h04);
      pad_in[6] = 1'b0; settle();
      rd(3'd3, v);
      chk(v[0] == 1'b0, "R9 level blocked", v, 8'h00);
      pad_in[6] = 1'b1;

      // R7 second reset, opposite straps: line3=0 line5=1 line4=0
      @(negedge clk);
      rst_n = 1'b0; pad_in = 8'hE0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pad_in = 8'h18;
      settle();
      rd(3'd6, v);
      chk(v == 8'h02, "R7 strap second reset", v, 8'h02);
      chk(pad_oe == 8'h00, "R1 pad_oe after second reset", pad_oe, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule